// File: doc/BRIEF.md
# Single-Cycle Add Execution Unit with Condition Flags

This block executes one 32-bit add instruction per clock. It decodes the instruction word and reads two operands from a 16-entry register file of 32-bit registers. The second operand is either a register or a zero-extended 8-bit constant. The block adds the two operands and writes the sum to the destination register on the same rising edge. It also keeps four 1-bit condition flags: negative, zero, carry and overflow. A flag-update bit in the instruction writes all four flags together, or leaves all four alone.

A small control decoder turns the instruction into three strobes: operand select, register write and flag write. These strobes are brought out as ports so that the control table can be checked for every instruction form. The decoder accepts only the one encoding it knows. It checks the condition field, the class bits, the opcode and the bits that must be zero. Any other word, or a cycle with the valid input low, leaves the architectural state untouched. The sum is also shown on a result port in the cycle it is computed. Register contents can therefore be read back by adding the constant zero to them.

Top module: `addx_unit`

## Requirements
- R1: Register form (instruction bit 25 = 0): the destination register (bits 15:12) receives the sum of the first operand register (bits 19:16) and the register in bits 3:0, on the rising edge that ends the cycle.
- R2: Immediate form (bit 25 = 1): the second operand is bits 7:0 zero-extended to 32 bits, so a constant with its top bit set never sign-extends.
- R3: When bit 20 is 1, all four flags are written on the same edge as the register. N takes bit 31 of the sum. Z is 1 exactly when the sum is all zeros.
- R4: With bit 20 set, C takes the carry out of the 32-bit unsigned addition. V is 1 when both operands have the same sign bit and the sum's sign bit differs from it.
- R5: When bit 20 is 0, none of the four flags changes, even if the addition carries or overflows. The destination register is still written.
- R6: While instrValid is low, neither the register file nor the flags are written. The regWrite and flagWrite ports are both 0.
- R7: The instruction is accepted only if bits 31:28 = 1110, bits 27:26 = 00, bits 24:21 = 0100, and the reserved bits are zero (bits 11:4 in register form, bits 11:8 in immediate form). Any other word writes nothing.
- R8: Control outputs: opSelImm equals bit 25. regWrite is 1 for a valid, accepted instruction. flagWrite is 1 only when regWrite is 1 and bit 20 is 1.
- R9: A synchronous active-high reset clears all four flags and every register to zero.
- R10: The result port shows the sum combinationally during the cycle. When the destination is also a source, the add uses the value the register held before the edge, and the new value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| result | output | 32 | Sum computed this cycle |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| opSelImm | output | 1 | Second operand select: 1 = immediate |
| regWrite | output | 1 | Register file write strobe |
| flagWrite | output | 1 | Flag register write strobe |

## Verification
The register write and the flag update share one clock edge. The destination register can also be a source of the same instruction. The bench provokes both cases by running self-accumulating adds with the flag bit set. It then reads the written register back with a following add of zero. Each add's result port must reflect the old register value. The flags after the edge must match the full sum, and the readback must show the new value. Carry-and-overflow adds with the flag bit clear show that the register update goes ahead while the flags stay frozen.

// File: rtl/addx_pkg.sv
package addx_pkg;
  localparam int DATA_W  = 32;
  localparam int REG_CNT = 16;
  localparam int IMM_W   = 8;
  localparam int ADDR_W  = $clog2(REG_CNT);

  localparam logic [3:0] COND_ALWAYS = 4'b1110;
  localparam logic [3:0] OPC_ADD     = 4'b0100;
  localparam logic [1:0] CLASS_DP    = 2'b00;

  typedef struct packed {
    logic opSelImm;
    logic regWrite;
    logic flagWrite;
  } ctrlStrobes_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/addx_ctrl.sv
module addx_ctrl
  import addx_pkg::*;
(
  input  logic         instrValid,
  input  logic [11:0]  hiField,   // instruction bits 31:20
  input  logic [7:0]   midField,  // instruction bits 11:4
  output ctrlStrobes_t strobes
);
  logic condOk, classOk, opOk, resvOk, immSel, setFlags, accept;

  assign condOk   = (hiField[11:8] == COND_ALWAYS);
  assign classOk  = (hiField[7:6] == CLASS_DP);
  assign immSel   = hiField[5];
  assign opOk     = (hiField[4:1] == OPC_ADD);
  assign setFlags = hiField[0];
  assign resvOk   = immSel ? (midField[7:4] == 4'b0) : (midField == 8'b0);
  assign accept   = instrValid && condOk && classOk && opOk && resvOk;

  always_comb begin
    strobes.opSelImm  = immSel;
    strobes.regWrite  = accept;
    strobes.flagWrite = accept && setFlags;
  end
endmodule

// File: rtl/addx_regfile.sv
module addx_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rdAddrA,
  output logic [WIDTH-1:0] rdDataA,
  input  logic [AW-1:0]    rdAddrB,
  output logic [WIDTH-1:0] rdDataB,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData
);
  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];
endmodule

// File: rtl/addx_adder.sv
module addx_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             overflow
);
  logic [WIDTH:0] wide;

  assign wide     = {1'b0, opA} + {1'b0, opB};
  assign sum      = wide[WIDTH-1:0];
  assign carryOut = wide[WIDTH];
  assign overflow = (opA[WIDTH-1] == opB[WIDTH-1]) && (sum[WIDTH-1] != opA[WIDTH-1]);
endmodule

// File: rtl/addx_datapath.sv
module addx_datapath
  import addx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] rnAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] rmAddr,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output nzcv_t             flags
);
  logic [DATA_W-1:0] rnData, rmData, opB, sum;
  logic              carryOut, overflow;
  nzcv_t             nextFlags;

  addx_regfile #(.WIDTH(DATA_W), .DEPTH(REG_CNT)) regFile (
    .clk(clk), .rst(rst),
    .rdAddrA(rnAddr), .rdDataA(rnData),
    .rdAddrB(rmAddr), .rdDataB(rmData),
    .wrEn(strobes.regWrite), .wrAddr(rdAddr), .wrData(sum)
  );

  assign opB = strobes.opSelImm ? {{(DATA_W-IMM_W){1'b0}}, immVal} : rmData;

  addx_adder #(.WIDTH(DATA_W)) adder (
    .opA(rnData), .opB(opB), .sum(sum), .carryOut(carryOut), .overflow(overflow)
  );

  always_comb begin
    nextFlags.n = sum[DATA_W-1];
    nextFlags.z = (sum == '0);
    nextFlags.c = carryOut;
    nextFlags.v = overflow;
  end

  always_ff @(posedge clk) begin
    if (rst)                    flags <= '0;
    else if (strobes.flagWrite) flags <= nextFlags;
  end

  assign result = sum;
endmodule

// File: rtl/addx_unit.sv
module addx_unit
  import addx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instrValid,
  input  logic [31:0] instr,
  output logic [31:0] result,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagC,
  output logic        flagV,
  output logic        opSelImm,
  output logic        regWrite,
  output logic        flagWrite
);
  ctrlStrobes_t strobes;
  nzcv_t        flags;

  addx_ctrl ctrl (
    .instrValid(instrValid),
    .hiField(instr[31:20]),
    .midField(instr[11:4]),
    .strobes(strobes)
  );

  addx_datapath datapath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .rnAddr(instr[19:16]), .rdAddr(instr[15:12]), .rmAddr(instr[3:0]),
    .immVal(instr[7:0]),
    .result(result), .flags(flags)
  );

  assign {flagN, flagZ, flagC, flagV} = flags;
  assign opSelImm  = strobes.opSelImm;
  assign regWrite  = strobes.regWrite;
  assign flagWrite = strobes.flagWrite;
endmodule

// File: rtl/addx_unit_chk.sv
module addx_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        instrValid,
  input logic [31:0] result,
  input logic        flagN,
  input logic        flagZ,
  input logic        flagC,
  input logic        flagV,
  input logic        regWrite,
  input logic        flagWrite
);
  // R9
  reset_clears_flags_chk: assert property (@(posedge clk)
    rst |=> ({flagN, flagZ, flagC, flagV} == 4'b0000));

  // R3
  neg_from_sum_chk: assert property (@(posedge clk) disable iff (rst)
    flagWrite |=> (flagN == $past(result[31])));

  // R3
  zero_from_sum_chk: assert property (@(posedge clk) disable iff (rst)
    flagWrite |=> (flagZ == ($past(result) == 32'h0)));

  // R5
  flags_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !flagWrite |=> $stable({flagN, flagZ, flagC, flagV}));

  // R6
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> (!regWrite && !flagWrite));

  // R8
  flag_implies_reg_chk: assert property (@(posedge clk) disable iff (rst)
    flagWrite |-> regWrite);
endmodule

bind addx_unit addx_unit_chk unitChk (
  .clk(clk), .rst(rst), .instrValid(instrValid), .result(result),
  .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
  .regWrite(regWrite), .flagWrite(flagWrite)
);

// File: tb/addx_unit_test.sv
module addx_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] result;
  logic        flagN, flagZ, flagC, flagV, opSelImm, regWrite, flagWrite;

  always #5 clk = ~clk;

  addx_unit uut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr),
    .result(result), .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .opSelImm(opSelImm), .regWrite(regWrite), .flagWrite(flagWrite)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mReg [16];
  logic [3:0]  mFlg;  // {N,Z,C,V}

  typedef struct {
    logic [31:0] res;
    logic        sel, rw, fw;
    logic [3:0]  flg;
    string       tag;
  } item_t;
  item_t pending[$];

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] regF(bit s, logic [3:0] rn, logic [3:0] rd, logic [3:0] rm);
    return {4'b1110, 2'b00, 1'b0, 4'b0100, s, rn, rd, 8'h00, rm};
  endfunction

  function automatic logic [31:0] immF(bit s, logic [3:0] rn, logic [3:0] rd, logic [7:0] imm);
    return {4'b1110, 2'b00, 1'b1, 4'b0100, s, rn, rd, 4'h0, imm};
  endfunction

  task automatic issue(logic [31:0] ins, logic v, string tag);
    item_t it;
    logic [32:0] wide;
    logic [31:0] a, b;
    logic legal;
    legal = (ins[31:28] == 4'b1110) && (ins[27:26] == 2'b00) && (ins[24:21] == 4'b0100) &&
            (ins[25] ? (ins[11:8] == 4'h0) : (ins[11:4] == 8'h00));
    a = mReg[ins[19:16]];
    b = ins[25] ? {24'h0, ins[7:0]} : mReg[ins[3:0]];
    wide = {1'b0, a} + {1'b0, b};
    it.res = wide[31:0];
    it.sel = ins[25];
    it.rw  = v && legal;
    it.fw  = it.rw && ins[20];
    it.tag = tag;
    if (it.fw)
      mFlg = {wide[31], wide[31:0] == 32'h0, wide[32], (a[31] == b[31]) && (wide[31] != a[31])};
    it.flg = mFlg;
    if (it.rw) mReg[ins[15:12]] = wide[31:0];
    @(negedge clk);
    instr = ins;
    instrValid = v;
    pending.push_back(it);
  endtask

  task automatic drain();
    wait (pending.size() == 0);
    @(negedge clk);
    instrValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: compares design outputs against queued expectations
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (pending.size() > 0) begin
        it = pending.pop_front();
        check(it.tag, "result", result, it.res);
        check("R8", "opSelImm", {31'h0, opSelImm}, {31'h0, it.sel});
        check("R8", "regWrite", {31'h0, regWrite}, {31'h0, it.rw});
        check("R8", "flagWrite", {31'h0, flagWrite}, {31'h0, it.fw});
        @(posedge clk);
        #1;
        check(it.tag, "flags", {28'h0, flagN, flagZ, flagC, flagV}, {28'h0, it.flg});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] bad;
    for (int i = 0; i < 16; i++) mReg[i] = 32'h0;
    mFlg = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9", "flags after reset", {28'h0, flagN, flagZ, flagC, flagV}, 32'h0);

    issue(immF(0, 0, 1, 8'hFF), 1, "R2");
    issue(regF(1, 1, 2, 1), 1, "R1");
    issue(immF(0, 0, 13, 8'h80), 1, "R2");
    issue(immF(1, 13, 13, 8'h00), 1, "R3");
    // build 0x7FFFFFFF by self-accumulation (R10)
    issue(immF(0, 0, 9, 8'h01), 1, "R10");
    for (int k = 0; k < 30; k++) begin
      issue(regF(0, 9, 9, 9), 1, "R10");
      issue(immF(0, 9, 9, 8'h01), 1, "R10");
    end
    issue(immF(1, 9, 10, 8'h01), 1, "R4");   // 0x80000000, N and V
    issue(regF(1, 10, 11, 9), 1, "R4");      // 0xFFFFFFFF, N only
    issue(immF(1, 11, 12, 8'h01), 1, "R4");  // 0, Z and C
    issue(regF(1, 10, 6, 10), 1, "R4");      // 0, Z C V
    issue(immF(1, 1, 3, 8'h02), 1, "R3");    // 0x101, all clear
    issue(regF(1, 12, 14, 9), 1, "R3");      // 0x7FFFFFFF
    // carry-producing add with flag bit clear (R5)
    issue(regF(0, 11, 4, 11), 1, "R5");
    issue(regF(0, 10, 5, 10), 1, "R5");
    issue(immF(0, 4, 7, 8'h00), 1, "R5");
    issue(immF(0, 5, 8, 8'h00), 1, "R5");
    // invalid cycle writes nothing (R6)
    issue(immF(1, 1, 7, 8'h03), 0, "R6");
    issue(immF(0, 7, 8, 8'h00), 1, "R6");
    // rejected encodings (R7)
    bad = immF(1, 1, 7, 8'h05); bad[31:28] = 4'h0;   issue(bad, 1, "R7");
    bad = immF(1, 1, 7, 8'h05); bad[24:21] = 4'h2;   issue(bad, 1, "R7");
    bad = immF(1, 1, 7, 8'h05); bad[27:26] = 2'b01;  issue(bad, 1, "R7");
    bad = immF(1, 1, 7, 8'h05); bad[8] = 1'b1;       issue(bad, 1, "R7");
    bad = regF(1, 1, 7, 1);     bad[4] = 1'b1;       issue(bad, 1, "R7");
    bad = regF(1, 1, 7, 1);     bad[11] = 1'b1;      issue(bad, 1, "R7");
    issue(immF(1, 7, 8, 8'h00), 1, "R7");
    // register form ignores nothing beyond bits 3:0 when reserved bits are zero
    issue(regF(1, 1, 15, 13), 1, "R1");
    // destination equals source with flag write in the same edge (R10)
    issue(regF(1, 2, 2, 1), 1, "R10");
    issue(regF(1, 2, 2, 2), 1, "R10");
    issue(immF(0, 2, 8, 8'h00), 1, "R10");
    issue(regF(1, 6, 8, 11), 1, "R3");       // N set before reset
    drain();

    // mid-run reset clears flags and registers (R9)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9", "flags after second reset", {28'h0, flagN, flagZ, flagC, flagV}, 32'h0);
    for (int i = 0; i < 16; i++) mReg[i] = 32'h0;
    mFlg = 4'h0;
    issue(immF(0, 2, 8, 8'h00), 1, "R9");
    issue(regF(0, 11, 8, 9), 1, "R9");
    drain();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule